// File: doc/BRIEF.md
# Timer Capture and Compare Unit

This block sits beside a free-running 16-bit timer and attaches a single 16-bit holding register to it. A 4-bit mode field selects what the register does. In the capture modes, an edge condition on an external event pin copies the current timer value into the register. In the compare modes, the register is checked against the timer on every cycle, and an equality acts on an output pin. A special compare mode asks the timer to restart and can start an analog conversion.

Both kinds of event set a sticky interrupt flag, which software clears with a one-cycle clear strobe. Software reads the holding register directly and writes it with a one-cycle write strobe. All pins are plain level or strobe signals, so there is no back-pressure anywhere. Each write and each clear strobe takes effect at the next clock edge.

The event pin is asynchronous and passes through two synchronizing flops before edge detection. Two capture modes divide the rising edges with an internal counter, so a capture happens only on every 4th or every 16th edge.

Top module: `tcc_unit`

## Requirements
- R1: While rst_n is low, hold_rd_data is 0, and irq_flag, out_pin, timer_rst_req and adc_start_req are all 0.
- R2: An edge on evt_in that is set up before clock edge k is seen as an event at edge k+2. At that edge the capture stores the timer_val present just before edge k+2.
- R3: Mode 4'b0100 captures on each falling edge of evt_in and mode 4'b0101 captures on each rising edge. Each capture copies timer_val into the holding register and sets irq_flag. A later capture overwrites a value that has not been read.
- R4: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th rising edge. The edge count restarts from zero whenever the mode is outside these two codes, which includes 4'b0000. It also restarts in the first cycle after any mode change, and a rising edge in that cycle is not counted.
- R5: A hold_wr_en strobe loads hold_wr_data at the next edge. If a capture happens in the same cycle, the captured timer value wins. In all other cases the holding register does not change.
- R6: irq_flag stays set until a flag_clr strobe clears it. If a capture or a match falls in the same cycle as flag_clr, the flag stays set.
- R7: In a compare mode (mode[3:2] = 2'b10), a match event happens in the first cycle in which timer_val equals the holding register. No further match happens while that equality continues, including across a change between compare modes. Each match sets irq_flag.
- R8: In mode 4'b1000, a match drives out_pin high; in mode 4'b1001, a match drives it low. In the first cycle of either mode, out_pin is preset to the opposite level. A match in that same first cycle takes priority over the preset.
- R9: Mode 4'b1010 sets irq_flag on a match and leaves out_pin at its current level.
- R10: In mode 4'b1011, a match sets irq_flag and leaves out_pin unchanged. It also raises timer_rst_req for exactly one cycle. adc_start_req is raised in that same cycle only when adc_enabled was high in the match cycle.
- R11: In every mode outside the compare modes, out_pin is 0. Modes 4'b0000, 4'b0001 to 4'b0011 and 4'b11xx neither capture nor compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Current value of the free-running timer |
| evt_in | input | 1 | Asynchronous external event pin |
| mode | input | 4 | Operating mode field |
| adc_enabled | input | 1 | High when the converter is on; gates the conversion request |
| hold_wr_en | input | 1 | One-cycle write strobe for the holding register |
| hold_wr_data | input | 16 | Data for the holding register write |
| flag_clr | input | 1 | One-cycle clear strobe for the interrupt flag |
| hold_rd_data | output | 16 | Holding register contents |
| irq_flag | output | 1 | Sticky interrupt flag |
| out_pin | output | 1 | Compare output pin |
| timer_rst_req | output | 1 | One-cycle request to restart the timer |
| adc_start_req | output | 1 | One-cycle request to start a conversion |

## Verification
There are two collision cases. In the first, a hardware capture lands in the same cycle as a software write to the holding register. In the second, a capture or match sets the flag in the same cycle that software clears it.

The bench provokes both by sweeping the write strobe and the clear strobe across a range of offsets after an event pulse. Some of those offsets meet the capture cycle exactly two edges after the pin changes.

A behavioural reference model judges every cycle. It gives the timer value priority over the written data and setting priority over clearing.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef logic [3:0] tcc_mode_t;

  localparam tcc_mode_t M_OFF         = 4'b0000;
  localparam tcc_mode_t M_CAP_FALL    = 4'b0100;
  localparam tcc_mode_t M_CAP_RISE    = 4'b0101;
  localparam tcc_mode_t M_CAP_DIV_A   = 4'b0110;
  localparam tcc_mode_t M_CAP_DIV_B   = 4'b0111;
  localparam tcc_mode_t M_CMP_SET     = 4'b1000;
  localparam tcc_mode_t M_CMP_CLR     = 4'b1001;
  localparam tcc_mode_t M_CMP_FLAG    = 4'b1010;
  localparam tcc_mode_t M_CMP_SPECIAL = 4'b1011;

  function automatic logic is_cmp(tcc_mode_t m);
    return m[3:2] == 2'b10;
  endfunction

  function automatic logic is_div(tcc_mode_t m);
    return (m == M_CAP_DIV_A) || (m == M_CAP_DIV_B);
  endfunction
endpackage

// File: rtl/tcc_evt_sync.sv
module tcc_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= evt_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/tcc_edge_prescale.sv
module tcc_edge_prescale #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sel_b,
  input  logic rise,
  output logic tick
);
  localparam int DMAX = (DIV_B > DIV_A) ? DIV_B : DIV_A;
  localparam int CW   = (DMAX > 2) ? $clog2(DMAX) : 1;
  localparam logic [CW-1:0] LIM_A = CW'(DIV_A - 1);
  localparam logic [CW-1:0] LIM_B = CW'(DIV_B - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = sel_b ? LIM_B : LIM_A;
  assign tick = rise & ~clear & (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else if (rise)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic [W-1:0] timer,
  input  logic [W-1:0] cmp_val,
  output logic         fire
);
  logic eq;
  logic matched_q;

  assign eq   = (timer == cmp_val);
  assign fire = active & eq & ~matched_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) matched_q <= 1'b0;
    else        matched_q <= active & eq;
endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
  import tcc_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic          evt_in,
  input  logic [3:0]    mode,
  input  logic          adc_enabled,
  input  logic          hold_wr_en,
  input  logic [TW-1:0] hold_wr_data,
  input  logic          flag_clr,
  output logic [TW-1:0] hold_rd_data,
  output logic          irq_flag,
  output logic          out_pin,
  output logic          timer_rst_req,
  output logic          adc_start_req
);
  tcc_mode_t mode_q;
  logic      entry;
  logic      ev_rise, ev_fall, div_tick;
  logic      cap_ev, cmp_fire, set_ev;
  logic      special;
  logic      out_nx;
  logic [TW-1:0] hold_q;

  assign entry = (mode != mode_q);

  tcc_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .evt_async(evt_in),
    .rise(ev_rise), .fall(ev_fall)
  );

  tcc_edge_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_div (
    .clk(clk), .rst_n(rst_n),
    .clear(~is_div(mode) | entry),
    .sel_b(mode == M_CAP_DIV_B),
    .rise(ev_rise), .tick(div_tick)
  );

  tcc_compare #(.W(TW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .active(is_cmp(mode)),
    .timer(timer_val), .cmp_val(hold_q), .fire(cmp_fire)
  );

  always_comb begin
    cap_ev = 1'b0;
    unique case (mode)
      M_CAP_FALL:               cap_ev = ev_fall;
      M_CAP_RISE:               cap_ev = ev_rise;
      M_CAP_DIV_A, M_CAP_DIV_B: cap_ev = div_tick;
      default:                  cap_ev = 1'b0;
    endcase
  end

  assign set_ev  = cap_ev | cmp_fire;
  assign special = cmp_fire & (mode == M_CMP_SPECIAL);

  always_comb begin
    out_nx = 1'b0;
    case (mode)
      M_CMP_SET:     out_nx = cmp_fire ? 1'b1 : (entry ? 1'b0 : out_pin);
      M_CMP_CLR:     out_nx = cmp_fire ? 1'b0 : (entry ? 1'b1 : out_pin);
      M_CMP_FLAG,
      M_CMP_SPECIAL: out_nx = out_pin;
      default:       out_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q        <= M_OFF;
      hold_q        <= '0;
      irq_flag      <= 1'b0;
      out_pin       <= 1'b0;
      timer_rst_req <= 1'b0;
      adc_start_req <= 1'b0;
    end else begin
      mode_q <= mode;
      if (cap_ev)          hold_q <= timer_val;
      else if (hold_wr_en) hold_q <= hold_wr_data;
      if (set_ev)          irq_flag <= 1'b1;
      else if (flag_clr)   irq_flag <= 1'b0;
      out_pin       <= out_nx;
      timer_rst_req <= special;
      adc_start_req <= special & adc_enabled;
    end
  end

  assign hold_rd_data = hold_q;
endmodule

// File: rtl/tcc_unit_chk.sv
module tcc_unit_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic          adc_enabled,
  input logic          hold_wr_en,
  input logic          flag_clr,
  input logic [TW-1:0] hold_rd_data,
  input logic          irq_flag,
  input logic          out_pin,
  input logic          timer_rst_req,
  input logic          adc_start_req
);
  p_out_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b10) |=> !out_pin);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);

  p_trst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timer_rst_req |=> !timer_rst_req);

  p_adc_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_req |-> (timer_rst_req && $past(adc_enabled)));

  p_trst_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timer_rst_req |-> ($past(mode) == 4'b1011));

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_wr_en && mode[3:2] != 2'b01) |=> $stable(hold_rd_data));

  p_off_no_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(mode) != 4'b0000));
endmodule

bind tcc_unit tcc_unit_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .adc_enabled(adc_enabled),
  .hold_wr_en(hold_wr_en), .flag_clr(flag_clr), .hold_rd_data(hold_rd_data),
  .irq_flag(irq_flag), .out_pin(out_pin), .timer_rst_req(timer_rst_req),
  .adc_start_req(adc_start_req)
);

// File: tb/tcc_unit_test.sv
`timescale 1ns/1ps
module tcc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr = 16'd0;
  logic        tmr_run = 1'b1;
  logic        evt = 1'b0;
  logic [3:0]  mode = 4'b0000;
  logic        adc_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'd0;
  logic        clr = 1'b0;
  logic [15:0] hold_rd;
  logic        flag, outp, trst, adcs;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string phase = "R1 reset";

  always #2.5 clk = ~clk;

  tcc_unit uut (
    .clk(clk), .rst_n(rst_n), .timer_val(tmr), .evt_in(evt), .mode(mode),
    .adc_enabled(adc_en), .hold_wr_en(wr_en), .hold_wr_data(wr_data),
    .flag_clr(clr), .hold_rd_data(hold_rd), .irq_flag(flag), .out_pin(outp),
    .timer_rst_req(trst), .adc_start_req(adcs)
  );

  always @(negedge clk) if (tmr_run) tmr <= tmr + 16'd1;

  // reference model state
  bit          hist[$];
  logic [15:0] m_hold;
  bit          m_flag, m_out, m_trst, m_adc, m_eqp;
  logic [3:0]  m_mode;
  int          m_cnt;

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {1'b0, 1'b0, 1'b0};
      m_hold = 0; m_flag = 0; m_out = 0; m_trst = 0; m_adc = 0;
      m_eqp = 0; m_mode = 0; m_cnt = 0;
    end else begin
      bit s2, s3, rise_e, fall_e, entry, cap, cmpm, eq, fire;
      int lim;
      s2 = hist[hist.size()-2];
      s3 = hist[hist.size()-3];
      rise_e = s2 && !s3;
      fall_e = !s2 && s3;
      entry = (mode != m_mode);
      cap = 0;
      if (mode == 4'b0100 && fall_e) cap = 1;
      if (mode == 4'b0101 && rise_e) cap = 1;
      lim = (mode == 4'b0111) ? 16 : 4;
      if (!(mode == 4'b0110 || mode == 4'b0111) || entry) m_cnt = 0;
      else if (rise_e) begin
        if (m_cnt == lim - 1) begin cap = 1; m_cnt = 0; end
        else m_cnt++;
      end
      cmpm = (mode[3:2] == 2'b10);
      eq = (tmr == m_hold);
      fire = cmpm && eq && !m_eqp;
      m_eqp = cmpm && eq;
      case (mode)
        4'b1000: m_out = fire ? 1 : (entry ? 0 : m_out);
        4'b1001: m_out = fire ? 0 : (entry ? 1 : m_out);
        4'b1010, 4'b1011: ;
        default: m_out = 0;
      endcase
      if (cap) m_hold = tmr;
      else if (wr_en) m_hold = wr_data;
      if (cap || fire) m_flag = 1;
      else if (clr) m_flag = 0;
      m_trst = fire && (mode == 4'b1011);
      m_adc = m_trst && adc_en;
      m_mode = mode;
      hist.push_back(evt);
      void'(hist.pop_front());
    end
    #1;
    chk("hold", hold_rd, m_hold);
    chk("flag", {15'd0, flag}, {15'd0, m_flag});
    chk("out", {15'd0, outp}, {15'd0, m_out});
    chk("trst", {15'd0, trst}, {15'd0, m_trst});
    chk("adc", {15'd0, adcs}, {15'd0, m_adc});
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    evt = 1'b1; cyc(hi);
    evt = 1'b0; cyc(lo);
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d; cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic clear_flag();
    clr = 1'b1; cyc(1);
    clr = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired in phase %s", phase);
      summary();
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);

    phase = "R2 R3 rising capture";
    mode = 4'b0101; cyc(2);
    for (int i = 0; i < 4; i++) pulse(3, 3 + i);
    clear_flag(); cyc(2);
    phase = "R3 falling capture";
    mode = 4'b0100; cyc(2);
    for (int i = 0; i < 3; i++) pulse(2, 4);

    phase = "R4 divide by 4";
    mode = 4'b0110; cyc(2); clear_flag();
    for (int i = 0; i < 9; i++) pulse(2, 2);
    phase = "R4 R11 restart via off";
    mode = 4'b0000; pulse(2, 2); cyc(2);
    mode = 4'b0110; clear_flag();
    for (int i = 0; i < 5; i++) pulse(2, 2);
    phase = "R4 divide by 16";
    mode = 4'b0111; cyc(2);
    for (int i = 0; i < 34; i++) pulse(1, 2);

    phase = "R5 R6 write and clear collisions";
    mode = 4'b0101; cyc(2);
    for (int off = 0; off < 5; off++) begin
      evt = 1'b1; cyc(off);
      wr_en = 1'b1; wr_data = 16'hA500 + 16'(off); clr = 1'b1; cyc(1);
      wr_en = 1'b0; clr = 1'b0; cyc(3);
      evt = 1'b0; cyc(4);
    end
    phase = "R5 plain write";
    mode = 4'b0001; wr(16'h1234); cyc(2);

    phase = "R7 R8 set on match";
    tmr_run = 1'b0; tmr = 16'd100; wr(16'd110); clear_flag();
    mode = 4'b1000; cyc(2); tmr_run = 1'b1; cyc(16);
    phase = "R7 no repeat while equal";
    tmr_run = 1'b0; tmr = 16'd120; clear_flag(); wr(16'd120); cyc(6);
    clear_flag(); cyc(4);
    phase = "R7 R8 clear on match";
    mode = 4'b1001; cyc(3);
    tmr = 16'd119; cyc(1); tmr = 16'd120; cyc(4);
    phase = "R8 match at entry";
    mode = 4'b0001; tmr = 16'd50; wr(16'd50); clear_flag();
    mode = 4'b1000; cyc(4);

    phase = "R9 flag only";
    mode = 4'b1010; clear_flag(); tmr = 16'd60; wr(16'd62); cyc(2);
    tmr_run = 1'b1; cyc(6);
    phase = "R10 special no adc";
    tmr_run = 1'b0; clear_flag(); tmr = 16'd200; wr(16'd203);
    mode = 4'b1011; adc_en = 1'b0; tmr_run = 1'b1; cyc(8);
    phase = "R10 special with adc";
    tmr_run = 1'b0; tmr = 16'd300; wr(16'd303); clear_flag();
    adc_en = 1'b1; tmr_run = 1'b1; cyc(8);

    phase = "R11 idle modes";
    for (int m = 0; m < 4; m++) begin
      mode = (m < 2) ? 4'(m) : 4'(4'b1100 + m);
      tmr_run = 1'b0; tmr = hold_rd; tmr_run = 1'b1;
      pulse(2, 3); pulse(2, 3);
    end
    phase = "R1 reset again";
    rst_n = 1'b0; cyc(3);
    rst_n = 1'b1; cyc(3);

    done = 1;
    summary();
    $finish;
  end
endmodule